// File: doc/BRIEF.md
# IDE Channel Strobe Timing Generator

This block times the read and write strobes of one IDE channel that serves two drives. Software programs a 16-bit channel timing word and an 8-bit secondary-drive timing byte. The block then takes one command at a time: a drive select, a read or write flag, and a flag that marks the cycle as DMA or PIO. Each command runs as an address setup phase, an active read or write strobe, and a recovery phase. Every duration is a whole number of host clocks.

Each drive has its own controls: a fast timing enable, an IORDY sampling enable, and a flag that limits fast timing to DMA cycles. The fast timing lengths come from two 2-bit codes: a sample-point code that sets the strobe width, and a recovery code. Drive 1 can take these two codes from the secondary byte instead of the channel word. A cycle without fast timing uses a fixed, slow compatible profile. The top bit of the word turns the whole channel on. While it is clear, the block starts no cycles.

The controller is a state machine with five states. IDLE waits for a command. A command accepted while the channel is enabled moves it to SETUP, which asserts `addr_setup`. When the setup count ends, SETUP goes to ACTIVE, which asserts the selected strobe. At the end of the strobe count, ACTIVE goes to STRETCH if IORDY sampling is on and `iordy` is low; otherwise it goes to RECOVER. STRETCH keeps the strobe asserted and moves to RECOVER at the first clock edge where `iordy` is high. RECOVER asserts `recovery` and returns to IDLE when its count ends. All lengths are latched when the command is accepted.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset, the channel word reads 0x8000 (decode enable set, all other bits clear), the secondary byte reads 0x00, and `busy`, `addr_setup`, `rd_strobe`, `wr_strobe` and `recovery` are all low.
- R2: A write with `reg_sel`=0 stores all 16 bits of `reg_wdata` as the channel word. A write with `reg_sel`=1 stores bits 7:0 as the secondary byte. `reg_rdata` shows the selected register combinationally, with the byte zero-extended. Channel word fields: bit 0 fast enable drive 0, bit 1 IORDY enable drive 0, bit 2 DMA-only drive 0, bit 4 fast enable drive 1, bit 5 IORDY enable drive 1, bit 6 DMA-only drive 1, bits 9:8 recovery code, bits 13:12 sample-point code, bit 14 secondary timing enable, bit 15 decode enable. Secondary byte fields: bits 1:0 recovery code for drive 1, bits 5:4 sample-point code for drive 1.
- R3: Under fast timing, the setup phase lasts 2 clocks and the strobe lasts 5, 4, 3 or 2 clocks for sample-point codes 0, 1, 2, 3.
- R4: Under fast timing, the recovery phase lasts 4, 3, 2 or 1 clocks for recovery codes 0, 1, 2, 3.
- R5: A cycle on a drive whose fast enable bit is clear uses compatible timing: 3 setup clocks, 10 strobe clocks and 5 recovery clocks.
- R6: When a drive's DMA-only bit is set, its PIO cycles use compatible timing and its DMA cycles use fast timing.
- R7: When bit 14 is set, drive 1 takes its codes from the secondary byte. When bit 14 is clear, drive 1 uses the channel word codes. Drive 0 always uses the channel word codes.
- R8: With the drive's IORDY enable set, the strobe stays asserted past its count until the first clock edge that samples `iordy` high. With the enable clear, `iordy` has no effect on the strobe width.
- R9: While busy, exactly one of `addr_setup`, `rd_strobe`, `wr_strobe`, `recovery` is high. The phases run in the order setup, strobe, recovery. Reads drive only `rd_strobe` and writes drive only `wr_strobe`.
- R10: `busy` rises in the cycle after a command is accepted and falls after the last recovery clock. Commands presented while busy are ignored, and `cyc_drive` holds the accepted drive for the whole cycle.
- R11: While bit 15 of the channel word is clear, `cmd_valid` starts no cycle.
- R12: A register write during a cycle does not change the lengths of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the channel word, 1 selects the secondary byte |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents |
| cmd_valid | input | 1 | Command request |
| cmd_drive | input | 1 | Drive select, 0 or 1 |
| cmd_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cmd_dma | input | 1 | 1 for a DMA cycle, 0 for a PIO cycle |
| iordy | input | 1 | Drive ready line |
| busy | output | 1 | High from command accept to end of recovery |
| addr_setup | output | 1 | Address setup phase |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| recovery | output | 1 | Recovery phase |
| cyc_drive | output | 1 | Drive of the cycle in progress |

## Verification
The assertions check on every cycle the phase encoding and its order, the holding of `cyc_drive`, the fact that a cycle always starts in setup and ends from recovery, and that a disabled or idle channel with no request stays idle. The exact phase lengths can only be shown by the bench's scenarios, which count clocks in each phase against a model of the requirements. The same holds for decoding both code fields, for the compatible and DMA-only fallbacks, for the secondary timing selection, for IORDY stretching by a chosen number of clocks, and for register writes that land in the middle of a cycle.

// File: rtl/ide_tim_pkg.sv
package ide_tim_pkg;

    // Channel word field positions (drive 1 fields sit 4 bits above drive 0)
    localparam int unsigned B_FAST    = 0;
    localparam int unsigned B_IORDY   = 1;
    localparam int unsigned B_DMAONLY = 2;
    localparam int unsigned DRV_STEP  = 4;
    localparam int unsigned B_RCT_LO  = 8;
    localparam int unsigned B_ISP_LO  = 12;
    localparam int unsigned B_SLV_EN  = 14;
    localparam int unsigned B_DEC_EN  = 15;

    // Secondary byte field positions
    localparam int unsigned S_RCT_LO  = 0;
    localparam int unsigned S_ISP_LO  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_STRETCH,
        ST_RECOVER
    } strobe_state_e;

    typedef struct packed {
        logic fast;
        logic iordy_en;
        logic dma_only;
    } drive_ctl_t;

    // sample-point code -> strobe clocks (5,4,3,2)
    function automatic logic [2:0] isp_clocks(input logic [1:0] code);
        return 3'd5 - {1'b0, code};
    endfunction

    // recovery code -> recovery clocks (4,3,2,1)
    function automatic logic [2:0] rct_clocks(input logic [1:0] code);
        return 3'd4 - {1'b0, code};
    endfunction

endpackage

// File: rtl/ide_tim_regs.sv
module ide_tim_regs #(
    parameter logic [15:0] WORD_RST = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] tim_word,
    output logic [7:0]  slv_byte,
    output logic [15:0] reg_rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_word <= WORD_RST;
            slv_byte <= '0;
        end else if (reg_wr) begin
            if (reg_sel) slv_byte <= reg_wdata[7:0];
            else         tim_word <= reg_wdata;
        end
    end

    assign reg_rdata = reg_sel ? {8'h00, slv_byte} : tim_word;

endmodule

// File: rtl/ide_tim_decode.sv
module ide_tim_decode
    import ide_tim_pkg::*;
#(
    parameter int CNT_W           = 4,
    parameter int FAST_SETUP      = 2,
    parameter int COMPAT_SETUP    = 3,
    parameter int COMPAT_ACTIVE   = 10,
    parameter int COMPAT_RECOVERY = 5
) (
    input  logic [15:0]      tim_word,
    input  logic [7:0]       slv_byte,
    input  logic             cmd_drive,
    input  logic             cmd_dma,
    output logic [CNT_W-1:0] setup_len,
    output logic [CNT_W-1:0] act_len,
    output logic [CNT_W-1:0] rec_len,
    output logic             iordy_en
);

    localparam int NUM_DRV = 2;

    drive_ctl_t ctl [NUM_DRV];

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        assign ctl[g] = '{
            fast:     tim_word[B_FAST    + DRV_STEP*g],
            iordy_en: tim_word[B_IORDY   + DRV_STEP*g],
            dma_only: tim_word[B_DMAONLY + DRV_STEP*g]
        };
    end

    drive_ctl_t  sel;
    logic        use_slv;
    logic        fast_ok;
    logic [1:0]  isp_code;
    logic [1:0]  rct_code;

    always_comb begin
        sel      = ctl[cmd_drive];
        use_slv  = cmd_drive && tim_word[B_SLV_EN];
        isp_code = use_slv ? slv_byte[S_ISP_LO +: 2] : tim_word[B_ISP_LO +: 2];
        rct_code = use_slv ? slv_byte[S_RCT_LO +: 2] : tim_word[B_RCT_LO +: 2];
        fast_ok  = sel.fast && (cmd_dma || !sel.dma_only);
        iordy_en = sel.iordy_en;
        if (fast_ok) begin
            setup_len = CNT_W'(FAST_SETUP);
            act_len   = CNT_W'(isp_clocks(isp_code));
            rec_len   = CNT_W'(rct_clocks(rct_code));
        end else begin
            setup_len = CNT_W'(COMPAT_SETUP);
            act_len   = CNT_W'(COMPAT_ACTIVE);
            rec_len   = CNT_W'(COMPAT_RECOVERY);
        end
    end

    logic unused_bits;
    assign unused_bits = ^{tim_word[3], tim_word[7], tim_word[11:10],
                           tim_word[B_DEC_EN], slv_byte[3:2], slv_byte[7:6]};

endmodule

// File: rtl/ide_tim_fsm.sv
module ide_tim_fsm
    import ide_tim_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_drive,
    input  logic             cmd_write,
    input  logic [CNT_W-1:0] setup_len,
    input  logic [CNT_W-1:0] act_len,
    input  logic [CNT_W-1:0] rec_len,
    input  logic             iordy_en,
    input  logic             iordy,
    output logic             busy,
    output logic             addr_setup,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic             recovery,
    output logic             cyc_drive
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    strobe_state_e    state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] act_q, rec_q;
    logic             ie_q, wr_q, drv_q;

    // state register and per-cycle latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            act_q <= '0;
            rec_q <= '0;
            ie_q  <= 1'b0;
            wr_q  <= 1'b0;
            drv_q <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (state == ST_IDLE && start) begin
                act_q <= act_len;
                rec_q <= rec_len;
                ie_q  <= iordy_en;
                wr_q  <= cmd_write;
                drv_q <= cmd_drive;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_SETUP;
                    cnt_nx   = setup_len - ONE;
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    state_nx = ST_ACTIVE;
                    cnt_nx   = act_q - ONE;
                end else begin
                    cnt_nx = cnt - ONE;
                end
            end
            ST_ACTIVE: begin
                if (cnt != '0) begin
                    cnt_nx = cnt - ONE;
                end else if (ie_q && !iordy) begin
                    state_nx = ST_STRETCH;
                end else begin
                    state_nx = ST_RECOVER;
                    cnt_nx   = rec_q - ONE;
                end
            end
            ST_STRETCH: begin
                if (iordy) begin
                    state_nx = ST_RECOVER;
                    cnt_nx   = rec_q - ONE;
                end
            end
            ST_RECOVER: begin
                if (cnt == '0) state_nx = ST_IDLE;
                else           cnt_nx   = cnt - ONE;
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        addr_setup = (state == ST_SETUP);
        rd_strobe  = (state == ST_ACTIVE || state == ST_STRETCH) && !wr_q;
        wr_strobe  = (state == ST_ACTIVE || state == ST_STRETCH) && wr_q;
        recovery   = (state == ST_RECOVER);
        cyc_drive  = drv_q;
    end

endmodule

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer
    import ide_tim_pkg::*;
#(
    parameter int          FAST_SETUP      = 2,
    parameter int          COMPAT_SETUP    = 3,
    parameter int          COMPAT_ACTIVE   = 10,
    parameter int          COMPAT_RECOVERY = 5,
    parameter logic [15:0] WORD_RST        = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        cmd_valid,
    input  logic        cmd_drive,
    input  logic        cmd_write,
    input  logic        cmd_dma,
    input  logic        iordy,
    output logic        busy,
    output logic        addr_setup,
    output logic        rd_strobe,
    output logic        wr_strobe,
    output logic        recovery,
    output logic        cyc_drive
);

    localparam int MAX_FAST_ACT = 5;
    localparam int MAX_A  = (COMPAT_ACTIVE > MAX_FAST_ACT) ? COMPAT_ACTIVE : MAX_FAST_ACT;
    localparam int MAX_S  = (COMPAT_SETUP > FAST_SETUP) ? COMPAT_SETUP : FAST_SETUP;
    localparam int MAX_R  = (COMPAT_RECOVERY > 4) ? COMPAT_RECOVERY : 4;
    localparam int MAX_AS = (MAX_A > MAX_S) ? MAX_A : MAX_S;
    localparam int MAX_L  = (MAX_AS > MAX_R) ? MAX_AS : MAX_R;
    localparam int CNT_W  = $clog2(MAX_L + 1);

    logic [15:0]      tim_word;
    logic [7:0]       slv_byte;
    logic [CNT_W-1:0] setup_len, act_len, rec_len;
    logic             iordy_en;
    logic             start;

    ide_tim_regs #(.WORD_RST(WORD_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .tim_word  (tim_word),
        .slv_byte  (slv_byte),
        .reg_rdata (reg_rdata)
    );

    ide_tim_decode #(
        .CNT_W           (CNT_W),
        .FAST_SETUP      (FAST_SETUP),
        .COMPAT_SETUP    (COMPAT_SETUP),
        .COMPAT_ACTIVE   (COMPAT_ACTIVE),
        .COMPAT_RECOVERY (COMPAT_RECOVERY)
    ) u_dec (
        .tim_word  (tim_word),
        .slv_byte  (slv_byte),
        .cmd_drive (cmd_drive),
        .cmd_dma   (cmd_dma),
        .setup_len (setup_len),
        .act_len   (act_len),
        .rec_len   (rec_len),
        .iordy_en  (iordy_en)
    );

    assign start = cmd_valid && tim_word[B_DEC_EN];

    ide_tim_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd_drive  (cmd_drive),
        .cmd_write  (cmd_write),
        .setup_len  (setup_len),
        .act_len    (act_len),
        .rec_len    (rec_len),
        .iordy_en   (iordy_en),
        .iordy      (iordy),
        .busy       (busy),
        .addr_setup (addr_setup),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .recovery   (recovery),
        .cyc_drive  (cyc_drive)
    );

endmodule

// File: rtl/ide_strobe_timer_chk.sv
module ide_strobe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic chan_en,
    input logic busy,
    input logic addr_setup,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic recovery,
    input logic cyc_drive
);

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot({addr_setup, rd_strobe, wr_strobe, recovery})); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(addr_setup || rd_strobe || wr_strobe || recovery)); // R9

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> addr_setup); // R9

    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe || wr_strobe) |-> $past(addr_setup)); // R9

    AST_END_FROM_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(recovery)); // R10

    AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(cyc_drive))); // R10

    AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (!chan_en || !cmd_valid)) |=> !busy); // R11

endmodule

bind ide_strobe_timer ide_strobe_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .chan_en    (tim_word[15]),
    .busy       (busy),
    .addr_setup (addr_setup),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .recovery   (recovery),
    .cyc_drive  (cyc_drive)
);

// File: tb/ide_strobe_timer_test.sv
`timescale 1ns/1ps
module ide_strobe_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_drive = 1'b0;
    logic        cmd_write = 1'b0;
    logic        cmd_dma = 1'b0;
    logic        iordy = 1'b1;
    logic        busy, addr_setup, rd_strobe, wr_strobe, recovery, cyc_drive;

    int tests = 0;
    int fails = 0;
    logic [15:0] sh_word = 16'h8000;
    logic [7:0]  sh_slv  = 8'h00;

    always #2.5 clk = ~clk;

    ide_strobe_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_drive(cmd_drive), .cmd_write(cmd_write), .cmd_dma(cmd_dma),
        .iordy(iordy), .busy(busy), .addr_setup(addr_setup),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .recovery(recovery),
        .cyc_drive(cyc_drive)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected phase lengths from the requirement text
    task automatic model(input logic [15:0] w, input logic [7:0] sl, input bit d,
                         input bit dma, output int s, output int a, output int r,
                         output bit ie);
        bit fast, dmo, use_slv;
        int isp, rct;
        fast    = w[4*d + 0];
        ie      = w[4*d + 1];
        dmo     = w[4*d + 2];
        use_slv = d && w[14];
        isp     = use_slv ? int'(sl[5:4]) : int'(w[13:12]);
        rct     = use_slv ? int'(sl[1:0]) : int'(w[9:8]);
        if (fast && (dma || !dmo)) begin
            s = 2; a = 5 - isp; r = 4 - rct;
        end else begin
            s = 3; a = 10; r = 5;
        end
    endtask

    task automatic wr_reg(input bit sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel) sh_slv = data[7:0];
        else     sh_word = data;
    endtask

    task automatic run_cmd(input bit d, input bit w, input bit dma, input int x,
                           input bit mid_wr, input logic [15:0] mid_word,
                           input bit mid_cmd, input string req);
        int s_e, a_e, r_e, exp_a;
        bit ie_e;
        int s = 0, a = 0, r = 0, other = 0, guard = 0, ph = 0, n;
        bit order_ok = 1, drv_ok = 1;
        model(sh_word, sh_slv, d, dma, s_e, a_e, r_e, ie_e);
        exp_a = (ie_e && x > 0) ? a_e + x : a_e;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_drive = d; cmd_write = w; cmd_dma = dma;
        iordy = (x > 0) ? 1'b0 : 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
        while (busy === 1'b1 && guard < 200) begin
            guard++;
            if (reg_wr) reg_wr = 1'b0;
            if (cmd_valid) cmd_valid = 1'b0;
            if (cyc_drive !== d) drv_ok = 0;
            n = int'(addr_setup) + int'(rd_strobe) + int'(wr_strobe) + int'(recovery);
            if (n != 1) order_ok = 0;
            if (addr_setup) begin
                if (ph > 0) order_ok = 0;
                s++;
                if (s == 1 && mid_wr) begin
                    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = mid_word;
                end
                if (s == 1 && mid_cmd) begin
                    cmd_valid = 1'b1; cmd_drive = !d;
                end
            end else if (rd_strobe || wr_strobe) begin
                if (ph > 1) order_ok = 0;
                ph = 1;
                if (w ? wr_strobe : rd_strobe) a++;
                else other++;
                if (x > 0 && (a + other) == a_e + x) iordy = 1'b1;
            end else if (recovery) begin
                ph = 2;
                r++;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0; cmd_valid = 1'b0; iordy = 1'b1;
        if (mid_wr) sh_word = mid_word;
        chk(s == s_e, {req, " setup clocks"}, s, s_e);
        chk(a == exp_a, {req, " strobe clocks"}, a, exp_a);
        chk(r == r_e, {req, " recovery clocks"}, r, r_e);
        chk(other == 0 && order_ok, "R9 phase order and strobe direction", other, 0);
        if (mid_cmd) begin
            chk(drv_ok, "R10 cyc_drive held", int'(drv_ok), 1);
            chk(busy === 1'b0, "R10 ignored command did not start", int'(busy), 0);
        end
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_sel = 1'b0; #1;
        chk(reg_rdata === 16'h8000, "R1 word reset", int'(reg_rdata), 16'h8000);
        reg_sel = 1'b1; #1;
        chk(reg_rdata === 16'h0000, "R1 byte reset", int'(reg_rdata), 0);
        chk({busy, addr_setup, rd_strobe, wr_strobe, recovery} === 5'b0,
            "R1 outputs idle", int'({busy, addr_setup, rd_strobe, wr_strobe, recovery}), 0);

        // R2 register write and read back
        wr_reg(1'b0, 16'h4C37);
        reg_sel = 1'b0; #1;
        chk(reg_rdata === 16'h4C37, "R2 word readback", int'(reg_rdata), 16'h4C37);
        wr_reg(1'b1, 16'hFFA5);
        reg_sel = 1'b1; #1;
        chk(reg_rdata === 16'h00A5, "R2 byte readback", int'(reg_rdata), 16'h00A5);
        wr_reg(1'b1, 16'h0000);

        // R5 compatible timing
        wr_reg(1'b0, 16'h8000);
        run_cmd(1'b0, 1'b0, 1'b0, 0, 1'b0, 16'h0, 1'b0, "R5 compat read");
        run_cmd(1'b1, 1'b1, 1'b1, 0, 1'b0, 16'h0, 1'b0, "R5 compat write");

        // R3 / R4 code decode
        for (int i = 0; i < 4; i++) begin
            wr_reg(1'b0, 16'h8001 | 16'(i << 12) | 16'((3 - i) << 8));
            run_cmd(1'b0, 1'b0, 1'b0, 0, 1'b0, 16'h0, 1'b0, "R3 R4 code decode");
        end

        // R6 DMA-only qualifier
        wr_reg(1'b0, 16'h8005 | 16'h2100);
        run_cmd(1'b0, 1'b0, 1'b0, 0, 1'b0, 16'h0, 1'b0, "R6 dma-only pio");
        run_cmd(1'b0, 1'b1, 1'b1, 0, 1'b0, 16'h0, 1'b0, "R6 dma-only dma");

        // R7 secondary timing set
        wr_reg(1'b1, 16'h0033);
        wr_reg(1'b0, 16'hC011);
        run_cmd(1'b1, 1'b0, 1'b0, 0, 1'b0, 16'h0, 1'b0, "R7 drive1 secondary");
        run_cmd(1'b0, 1'b0, 1'b0, 0, 1'b0, 16'h0, 1'b0, "R7 drive0 word");
        wr_reg(1'b0, 16'h8011);
        run_cmd(1'b1, 1'b1, 1'b0, 0, 1'b0, 16'h0, 1'b0, "R7 drive1 word");

        // R8 IORDY stretch and ignore
        wr_reg(1'b0, 16'h8003 | 16'h1000);
        run_cmd(1'b0, 1'b0, 1'b0, 3, 1'b0, 16'h0, 1'b0, "R8 stretch 3");
        run_cmd(1'b0, 1'b1, 1'b0, 1, 1'b0, 16'h0, 1'b0, "R8 stretch 1");
        wr_reg(1'b0, 16'h8001 | 16'h1000);
        run_cmd(1'b0, 1'b0, 1'b0, 3, 1'b0, 16'h0, 1'b0, "R8 iordy ignored");

        // R10 command while busy, R12 write mid-cycle
        run_cmd(1'b0, 1'b1, 1'b0, 0, 1'b0, 16'h0, 1'b1, "R10 busy cmd");
        run_cmd(1'b0, 1'b0, 1'b0, 0, 1'b1, 16'h8000, 1'b0, "R12 write mid-cycle");
        reg_sel = 1'b0; #1;
        chk(reg_rdata === 16'h8000, "R12 mid write landed", int'(reg_rdata), 16'h8000);

        // R11 disabled channel
        wr_reg(1'b0, 16'h0001);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_drive = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R11 disabled channel stays idle", int'(busy), 0);
        cmd_valid = 1'b0;
        @(negedge clk);

        // random mix
        wr_reg(1'b0, 16'h8000);
        for (int k = 0; k < 40; k++) begin
            wr_reg(1'b0, 16'($urandom()) | 16'h8000);
            wr_reg(1'b1, 16'($urandom()));
            run_cmd(1'($urandom()), 1'($urandom()), 1'($urandom()),
                    int'($urandom() % 4), 1'b0, 16'h0, 1'b0, "R3 R4 R5 R6 R7 R8 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule